// File: doc/BRIEF.md
# Data Access Overlay Redirector

This block sits between a processor's load/store port and the memory system. It compares each data access that targets the code segment against a set of programmable overlay windows. When an access falls inside an enabled window, the block rewrites the address so that the access goes to on-chip SRAM. Software can then edit parameters that normally live in non-volatile code memory while the program keeps using their original addresses. Instruction fetches are never redirected.

Each window has three registers: a target offset, a redirect base with an enable flag, and a mask. The mask works bit by bit. A mask bit of 1 means the address bit must equal the target bit, and the output bit is taken from the redirect base. A mask bit of 0 means the address bit is not compared, and the output bit is copied from the incoming address. A mask whose low N bits are zero and whose upper bits are one therefore gives an aligned window of 2^N bytes. Matching and remapping are combinational. Configuration writes are registered.

Top module: `ovl_redirect`

## Requirements
- R1: While reset is asserted and after it is released, every configuration register reads zero and no window is enabled, so no access is redirected.
- R2: A configuration write takes effect at the next rising clock edge and not before. Register select `cfg_addr[1:0]` picks the register: 0 is the target, 1 is the base, 2 is the mask, and 3 reads zero. `cfg_addr[5:2]` picks the window. Target and mask keep bits 27:0 and read bits 31:28 as zero. The base keeps bit 31 (enable) and bits 27:0, and reads bits 30:28 as zero.
- R3: An access hits window w when `acc_valid` is 1, `acc_fetch` is 0, `acc_addr[31:28]` equals 0xA, window w is enabled, and `acc_addr[27:0]` equals the window's target on every bit where the window's mask is 1.
- R4: On a hit, `out_addr[31:28]` is 0xC. Each bit of `out_addr[27:0]` comes from the base where the mask bit is 1 and from `acc_addr` where it is 0. For example, target 0x0000C000, base 0x80001000 and mask 0x0FFFFF00 map 0xA000C000..0xA000C0FF to 0xC0001000..0xC00010FF.
- R5: An access with `acc_fetch`=1 never hits. Its `out_addr` equals `acc_addr`.
- R6: Data reads and data writes (`acc_write` 0 or 1) are redirected in the same way. `out_write` follows `acc_write`.
- R7: An access whose top nibble is not 0xA never hits and passes through unchanged.
- R8: When several enabled windows match, the lowest-numbered one is used, and `out_win` reports its index. `out_win` is 0 when there is no hit.
- R9: A mask of all ones above N low zero bits (N from 1 to 9) covers exactly 2^N consecutive bytes, aligned at the target.
- R10: A window whose enable bit is 0 never hits, whatever its target and mask hold.
- R11: The outputs respond to the access inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | {window index, register select} |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read of the addressed register |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 for store, 0 for load |
| acc_fetch | input | 1 | 1 for instruction fetch |
| out_addr | output | 32 | Remapped or unchanged address |
| out_write | output | 1 | Copy of acc_write |
| out_hit | output | 1 | Access was redirected |
| out_win | output | 4 | Index of the window used |

## Verification
The bench sweeps each window size from 2 to 512 bytes across a span wider than the window and counts the hits. A mask decode that is off by one bit would give a window half or twice the right size, or would let neighbouring bytes hit. Overlapping windows are enabled and then disabled one at a time to catch a reversed priority or an ignored enable. Fetches, foreign segments and non-contiguous masks are mixed into a long randomised run, so a design that redirects fetches or takes all output bits from the base would disagree with the bench's bit-by-bit model. A write paired with an access in the same cycle shows whether the configuration is used too early.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int ADDR_W = 32;
  localparam int SEG_W  = 4;
  localparam int OFS_W  = ADDR_W - SEG_W;
  localparam logic [SEG_W-1:0] CODE_SEG = 4'hA;
  localparam logic [SEG_W-1:0] SRAM_SEG = 4'hC;
  localparam int EN_BIT = 31;

  localparam logic [31:0] KEEP_TGT  = 32'h0FFF_FFFF;
  localparam logic [31:0] KEEP_BASE = 32'h8FFF_FFFF;
  localparam logic [31:0] KEEP_MSK  = 32'h0FFF_FFFF;

  typedef enum logic [1:0] {
    SEL_TGT  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             en;
    logic [OFS_W-1:0] tgt;
    logic [OFS_W-1:0] base;
    logic [OFS_W-1:0] msk;
  } window_cfg_t;

  // compare only the bits the mask selects
  function automatic logic ovl_match(input logic [OFS_W-1:0] ofs,
                                     input logic [OFS_W-1:0] tgt,
                                     input logic [OFS_W-1:0] msk);
    return ((ofs ^ tgt) & msk) == '0;
  endfunction

  // masked bits from base, the rest from the incoming offset
  function automatic logic [OFS_W-1:0] ovl_remap(input logic [OFS_W-1:0] ofs,
                                                 input logic [OFS_W-1:0] base,
                                                 input logic [OFS_W-1:0] msk);
    return (base & msk) | (ofs & ~msk);
  endfunction
endpackage

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs
  import ovl_pkg::*;
#(
  parameter int NUM_WIN = 16,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int RA_W   = IDX_W + 2
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [RA_W-1:0]               addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output window_cfg_t [NUM_WIN-1:0]     cfg
);
  logic [IDX_W-1:0] addr_win;
  reg_sel_e         addr_sel;
  logic [31:0]      tgt_q  [NUM_WIN];
  logic [31:0]      base_q [NUM_WIN];
  logic [31:0]      msk_q  [NUM_WIN];

  assign addr_win = addr[RA_W-1:2];
  assign addr_sel = reg_sel_e'(addr[1:0]);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic wr_here;
    assign wr_here = we && (addr_win == IDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tgt_q[w]  <= '0;
        base_q[w] <= '0;
        msk_q[w]  <= '0;
      end else if (wr_here) begin
        case (addr_sel)
          SEL_TGT:  tgt_q[w]  <= wdata & KEEP_TGT;
          SEL_BASE: base_q[w] <= wdata & KEEP_BASE;
          SEL_MASK: msk_q[w]  <= wdata & KEEP_MSK;
          default:  ;
        endcase
      end
    end

    assign cfg[w].en   = base_q[w][EN_BIT];
    assign cfg[w].tgt  = tgt_q[w][OFS_W-1:0];
    assign cfg[w].base = base_q[w][OFS_W-1:0];
    assign cfg[w].msk  = msk_q[w][OFS_W-1:0];
  end

  always_comb begin
    rdata = '0;
    if (int'(addr_win) < NUM_WIN) begin
      case (addr_sel)
        SEL_TGT:  rdata = tgt_q[addr_win];
        SEL_BASE: rdata = base_q[addr_win];
        SEL_MASK: rdata = msk_q[addr_win];
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ovl_window_match.sv
module ovl_window_match
  import ovl_pkg::*;
(
  input  window_cfg_t      cfg,
  input  logic             qual,
  input  logic [OFS_W-1:0] ofs,
  output logic             hit
);
  logic cmp_ok;
  assign cmp_ok = ovl_match(ofs, cfg.tgt, cfg.msk);
  assign hit    = qual & cfg.en & cmp_ok;
endmodule

// File: rtl/ovl_first_hit.sv
module ovl_first_hit #(
  parameter int NUM_WIN = 16,
  localparam int IDX_W  = $clog2(NUM_WIN)
)(
  input  logic [NUM_WIN-1:0] vec,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  // scan from the top so the lowest set bit is written last
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ovl_redirect.sv
module ovl_redirect
  import ovl_pkg::*;
#(
  parameter int NUM_WIN = 16,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int RA_W   = IDX_W + 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  output logic [31:0]       out_addr,
  output logic              out_write,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_win
);
  window_cfg_t [NUM_WIN-1:0] cfg;
  logic [NUM_WIN-1:0]        hit_vec;
  logic [NUM_WIN-1:0]        en_vec;
  logic                      qual;
  logic                      any_hit;
  logic [IDX_W-1:0]          win_idx;
  window_cfg_t               sel_cfg;
  logic [OFS_W-1:0]          sel_mask;
  logic [OFS_W-1:0]          acc_ofs;
  logic [OFS_W-1:0]          new_ofs;

  ovl_cfg_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  assign acc_ofs = acc_addr[OFS_W-1:0];
  assign qual    = acc_valid && !acc_fetch && (acc_addr[ADDR_W-1:OFS_W] == CODE_SEG);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    assign en_vec[w] = cfg[w].en;
    ovl_window_match u_match (
      .cfg  (cfg[w]),
      .qual (qual),
      .ofs  (acc_ofs),
      .hit  (hit_vec[w])
    );
  end

  ovl_first_hit #(.NUM_WIN(NUM_WIN)) u_prio (
    .vec (hit_vec),
    .any (any_hit),
    .idx (win_idx)
  );

  assign sel_cfg  = cfg[win_idx];
  assign sel_mask = sel_cfg.msk;
  assign new_ofs  = ovl_remap(acc_ofs, sel_cfg.base, sel_mask);

  assign out_hit   = any_hit;
  assign out_win   = any_hit ? win_idx : '0;
  assign out_addr  = any_hit ? {SRAM_SEG, new_ofs} : acc_addr;
  assign out_write = acc_write;
endmodule

// File: rtl/ovl_redirect_chk.sv
module ovl_redirect_chk #(
  parameter int NUM_WIN = 16,
  localparam int IDX_W  = $clog2(NUM_WIN)
)(
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_fetch,
  input logic [31:0]        acc_addr,
  input logic [31:0]        out_addr,
  input logic               out_hit,
  input logic [IDX_W-1:0]   out_win,
  input logic [NUM_WIN-1:0] hit_vec,
  input logic [NUM_WIN-1:0] en_vec,
  input logic [27:0]        sel_mask
);
  logic [NUM_WIN-1:0] below_mask;
  assign below_mask = (NUM_WIN'(1) << out_win) - NUM_WIN'(1);

  assert_fetch_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fetch |-> (!out_hit && out_addr == acc_addr));

  assert_foreign_seg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[31:28] != 4'hA) |-> (!out_hit && out_addr == acc_addr));

  assert_hit_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> (acc_valid && hit_vec[out_win]));

  assert_sram_seg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> (out_addr[31:28] == 4'hC &&
                 (out_addr[27:0] & ~sel_mask) == (acc_addr[27:0] & ~sel_mask)));

  assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> ((hit_vec & below_mask) == '0));

  assert_enabled_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> en_vec[out_win]);

  assert_no_hit_without_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |-> (!out_hit && out_win == '0));
endmodule

bind ovl_redirect ovl_redirect_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_fetch (acc_fetch),
  .acc_addr  (acc_addr),
  .out_addr  (out_addr),
  .out_hit   (out_hit),
  .out_win   (out_win),
  .hit_vec   (hit_vec),
  .en_vec    (en_vec),
  .sel_mask  (sel_mask)
);

// File: tb/ovl_redirect_tb.sv
module ovl_redirect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_fetch = 1'b0;
  logic [31:0] out_addr;
  logic        out_write;
  logic        out_hit;
  logic [3:0]  out_win;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_tgt  [16];
  logic [31:0] m_base [16];
  logic [31:0] m_msk  [16];
  logic [31:0] e_addr;
  logic        e_hit;
  logic [3:0]  e_win;

  always #5 clk = ~clk;

  ovl_redirect u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .out_addr(out_addr), .out_write(out_write), .out_hit(out_hit), .out_win(out_win)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin
      m_tgt[i] = '0; m_base[i] = '0; m_msk[i] = '0;
    end
  endtask

  // bit-by-bit reference of match, priority and remap
  task automatic model_eval(input logic [31:0] a, input logic v, input logic f);
    e_hit = 0; e_win = 0; e_addr = a;
    if (v && !f && a[31:28] == 4'b1010) begin
      for (int i = 0; i < 16; i++) begin
        if (!e_hit && m_base[i][31]) begin
          bit ok = 1;
          for (int b = 0; b < 28; b++)
            if (m_msk[i][b] && (a[b] != m_tgt[i][b])) ok = 0;
          if (ok) begin
            e_hit = 1; e_win = 4'(i);
            e_addr[31:28] = 4'b1100;
            for (int b = 0; b < 28; b++)
              e_addr[b] = m_msk[i][b] ? m_base[i][b] : a[b];
          end
        end
      end
    end
  endtask

  task automatic cfg_write(input int win, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {4'(win), 2'(sel)}; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 0;
    case (sel)
      0: m_tgt[win]  = {4'h0, d[27:0]};
      1: m_base[win] = {d[31], 3'b000, d[27:0]};
      2: m_msk[win]  = {4'h0, d[27:0]};
      default: ;
    endcase
  endtask

  task automatic cfg_read(input int win, input int sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = {4'(win), 2'(sel)};
    #1 chk(cfg_rdata === exp, tag, cfg_rdata, exp);
  endtask

  task automatic access(input logic [31:0] a, input logic wr, input logic f, input string tag);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_write = wr; acc_fetch = f;
    #1;
    model_eval(a, 1'b1, f);
    chk(out_hit === e_hit && out_addr === e_addr && out_win === e_win && out_write === wr,
        tag, out_addr, e_addr);
  endtask

  task automatic set_win(input int w, input logic [31:0] t, input logic [31:0] b, input logic [31:0] m);
    cfg_write(w, 0, t); cfg_write(w, 2, m); cfg_write(w, 1, b);
  endtask

  initial begin
    #3ms;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hits;
    model_clear();
    repeat (3) @(posedge clk);
    // R1: registers read zero during reset
    for (int w = 0; w < 16; w++)
      for (int s = 0; s < 4; s++) cfg_read(w, s, 32'h0, "R1 reset readback");
    @(negedge clk) rst_n = 1;
    access(32'hA000C000, 0, 0, "R1 no hit after reset");
    access(32'hA0000000, 1, 0, "R1 no hit after reset");

    // R2: reserved bits drop, select 3 reads zero
    cfg_write(0, 0, 32'hF000C000);
    cfg_write(0, 2, 32'hFFFFFF00);
    cfg_write(0, 3, 32'hFFFFFFFF);
    cfg_read(0, 0, 32'h0000C000, "R2 target readback");
    cfg_read(0, 2, 32'h0FFFFF00, "R2 mask readback");
    cfg_read(0, 3, 32'h0, "R2 select 3 reads zero");

    // R2/R11: enable written in the same cycle as an access is not used until the edge
    @(negedge clk);
    cfg_we = 1; cfg_addr = {4'd0, 2'd1}; cfg_wdata = 32'hF0001000;
    acc_valid = 1; acc_addr = 32'hA000C010; acc_write = 0; acc_fetch = 0;
    #1 chk(out_hit === 1'b0 && out_addr === 32'hA000C010, "R2 write not visible early", out_addr, 32'hA000C010);
    @(posedge clk);
    #1 cfg_we = 0;
    m_base[0] = 32'h80001000;
    chk(out_hit === 1'b1 && out_addr === 32'hC0001010, "R11 same-cycle remap after edge", out_addr, 32'hC0001010);
    cfg_read(0, 1, 32'h80001000, "R2 base readback");

    // R4/R6/R5: example window, both directions, fetches untouched
    for (int i = -16; i < 272; i++) begin
      access(32'hA000C000 + 32'(i), 0, 0, "R4 read sweep");
      access(32'hA000C000 + 32'(i), 1, 0, "R6 write sweep");
      access(32'hA000C000 + 32'(i), 0, 1, "R5 fetch bypass");
    end
    chk(1'b1, "R4 example end", 0, 0);
    access(32'hA000C0FF, 1, 0, "R4 last byte");
    chk(out_addr === 32'hC00010FF, "R4 last byte maps to C00010FF", out_addr, 32'hC00010FF);

    // R7: other segments
    access(32'h2000C000, 0, 0, "R7 foreign segment");
    access(32'hB000C000, 1, 0, "R7 foreign segment");
    access(32'hC000C000, 0, 0, "R7 foreign segment");
    @(negedge clk) acc_valid = 0; acc_addr = 32'hA000C004;
    #1 chk(out_hit === 0 && out_addr === 32'hA000C004, "R3 invalid access ignored", out_addr, 32'hA000C004);

    // R9: window size from the mask's low zeros
    set_win(0, 32'h0, 32'h0, 32'h0);
    for (int k = 1; k <= 9; k++) begin
      set_win(2, 32'h00010000, 32'h80002000, 32'h0FFFFFFF << k);
      hits = 0;
      for (int a = 32'h00010000 - 520; a < 32'h00010000 + 1040; a++) begin
        access(32'hA0000000 | 32'(a), 0, 0, "R9 size sweep");
        if (out_hit) hits++;
      end
      chk(hits == (1 << k), "R9 window byte count", 32'(hits), 32'(1 << k));
    end

    // R8/R10: overlapping windows
    set_win(5, 32'h00020000, 32'h80005000, 32'h0FFFF000);
    set_win(3, 32'h00020040, 32'h80003000, 32'h0FFFFFC0);
    access(32'hA0020044, 0, 0, "R8 overlap");
    chk(out_win === 4'd3, "R8 lowest index wins", 32'(out_win), 32'd3);
    access(32'hA0020084, 0, 0, "R8 only higher matches");
    cfg_write(3, 1, 32'h00003000);
    access(32'hA0020044, 0, 0, "R10 disabled window skipped");
    chk(out_win === 4'd5, "R10 disabled window skipped", 32'(out_win), 32'd5);

    // R3/R4: randomised sweep, non-contiguous masks included
    for (int w = 0; w < 16; w++) begin
      logic [31:0] m;
      m = (w % 3 == 0) ? ($urandom & 32'h0FFFFFFF) : (32'h0FFFFFFF << ($urandom_range(1, 9)));
      set_win(w, $urandom, {1'($urandom_range(0, 3) != 0), 31'($urandom)}, m);
    end
    for (int n = 0; n < 3000; n++) begin
      int w;
      logic [31:0] a;
      w = $urandom_range(0, 15);
      a = {4'hA, m_tgt[w][27:0] ^ ($urandom & ~m_msk[w][27:0] & 28'h00003FF)};
      if (n % 7 == 0) a[$urandom_range(0, 27)] ^= 1'b1;
      if (n % 11 == 0) a[31:28] = 4'($urandom);
      access(a, 1'($urandom), 1'(n % 13 == 0), "R3 random access");
    end

    // R1: reset clears configuration again
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    model_clear();
    cfg_read(5, 1, 32'h0, "R1 base cleared");
    access(32'hA0020044, 0, 0, "R1 no hit after second reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule